// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for each bus address, which programmed protection region applies. It returns that region's memory attributes, or it returns a fault. It holds a parameterised number of regions (eight by default). Each region has a base address, a power-of-two size, an enable bit, an eight-bit subregion-disable mask, a two-bit access-permission code and three attribute bits: cacheable, bufferable and shareable. A disabled subregion does not belong to its region. Lookups that land in it fall through to any other enabled region that covers the address.

Software programs the regions through a plain word-write port with byte strobes. Lookups use a request/response stream. The request side has no ready signal and never applies back-pressure, so a request is accepted on every cycle that `req_valid` is high. Exactly one cycle later, `rsp_valid` is high and the response fields hold the result. The consumer must take the response in that cycle, because nothing is buffered. Response fields are meaningful only while `rsp_valid` is high. The plain control input `mpu_on` acts as a global bypass.

Top module: `mpu_region_check`

## Requirements
- R1: Register address `cfg_addr = {region, sel}`. `sel=0` is the base word. `sel=1` is the attribute word, with fields: bit 0 enable, bits 5:1 size code N, bits 15:8 subregion mask, bit 16 C, bit 17 B, bit 18 S, bits 25:24 permission. A region covers 2^(N+1) bytes starting at its base with the low N+1 bits cleared. An address inside an enabled region hits it.
- R2: A region with N >= 7 is split into eight equal subregions. Mask bit k removes subregion k from the region, where bit 0 is the lowest-addressed subregion.
- R3: An address in a removed subregion is matched by any other enabled region that covers it. Example: a 512KB region with mask 0b00000011 and a 128KB region at the same base. The 128KB region supplies the attributes for offsets 0 to 128KB.
- R4: With `mpu_on` high and no region matching after masking, the response is a fault with hit low, region number 0 and attributes 0.
- R5: When several regions match, the highest-numbered one is reported.
- R6: `rsp_c`, `rsp_b` and `rsp_s` equal the C, B and S bits of the reported region unchanged.
- R7: Permission codes: 00 privileged read/write only, 01 read/write for all, 10 privileged read-only, 11 read-only for all. A denied access reports hit high, fault high and the region's number and attributes.
- R8: For regions with N < 7 the subregion mask has no effect.
- R9: With `mpu_on` low, every response has hit low, fault low, region 0 and attributes 0.
- R10: A write to an attribute word takes effect only with `cfg_be = 4'b1111`. Any other strobe pattern leaves the word unchanged and raises `cfg_err` for the one cycle after the write. Base words accept per-byte writes.
- R11: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise.
- R12: After reset, every region is disabled and `rsp_valid` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mpu_on | input | 1 | Global enable; low bypasses all checks |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | IDXW+1 | {region index, word select} |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte strobes |
| cfg_err | output | 1 | Rejected attribute-word write, one cycle after it |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Lookup address |
| req_priv | input | 1 | Privileged access |
| req_write | input | 1 | Write access |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | A region matched |
| rsp_fault | output | 1 | Access faults |
| rsp_region | output | IDXW | Number of the matched region |
| rsp_c | output | 1 | Cacheable attribute |
| rsp_b | output | 1 | Bufferable attribute |
| rsp_s | output | 1 | Shareable attribute |

## Verification
The bench targets the edges of subregions, the same-base overlap case and the end of regions. A checker that picks the wrong subregion bit or mis-scales the subregion size returns the wrong region near those edges. Tiny regions carry full masks, so a design that applied the mask to them would report spurious faults. Stacked regions catch a priority inverted toward low numbers, and partial strobes on attribute words catch a design that accepts them. Randomly placed overlapping regions then catch off-by-one errors in alignment, size and permission decoding.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int ADDR_W    = 32;
  localparam int SUB_MIN_N = 7;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic              en;
    logic [4:0]        sz;
    logic [7:0]        sub_off;
    logic [1:0]        perm;
    logic              c;
    logic              b;
    logic              s;
  } mpu_region_t;

  // 00 priv rw, 01 all rw, 10 priv ro, 11 all ro
  function automatic logic perm_denies(input logic [1:0] perm,
                                       input logic priv, input logic wr);
    case (perm)
      2'b00:   return !priv;
      2'b01:   return 1'b0;
      2'b10:   return !priv || wr;
      default: return wr;
    endcase
  endfunction
endpackage

// File: rtl/mpu_region_regs.sv
module mpu_region_regs
  import mpu_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW:0]     cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_be,
  output logic              cfg_err,
  output mpu_region_t       regions [NREG]
);
  logic [IDXW-1:0] widx;
  logic            wsel_attr;
  logic            full_word;

  assign widx      = cfg_addr[IDXW:1];
  assign wsel_attr = cfg_addr[0];
  assign full_word = (cfg_be == 4'hF);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic hit_k;
    assign hit_k = cfg_we && (widx == IDXW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regions[k] <= '0;
      end else if (hit_k) begin
        if (!wsel_attr) begin
          for (int bb = 0; bb < 4; bb++)
            if (cfg_be[bb]) regions[k].base[8*bb +: 8] <= cfg_wdata[8*bb +: 8];
        end else if (full_word) begin
          regions[k].en      <= cfg_wdata[0];
          regions[k].sz      <= cfg_wdata[5:1];
          regions[k].sub_off <= cfg_wdata[15:8];
          regions[k].c       <= cfg_wdata[16];
          regions[k].b       <= cfg_wdata[17];
          regions[k].s       <= cfg_wdata[18];
          regions[k].perm    <= cfg_wdata[25:24];
        end
      end
    end

    AST_BAD_ATTR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_k && wsel_attr && !full_word) |=>
        $stable({regions[k].en, regions[k].sz, regions[k].sub_off,
                 regions[k].perm, regions[k].c, regions[k].b, regions[k].s})); // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= cfg_we && wsel_attr && !full_word;
  end

  AST_BAD_ATTR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr[0] && cfg_be != 4'hF) |=> cfg_err); // R10
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
(
  input  mpu_region_t        region,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] keep_mask;
  logic              in_range;
  logic [2:0]        sub_idx;
  logic              sub_cut;
  logic [ADDR_W-1:0] shifted;

  always_comb begin
    span      = (ADDR_W+1)'(1) << ({1'b0, region.sz} + 6'd1);
    keep_mask = ~(span[ADDR_W-1:0] - ADDR_W'(1));
    in_range  = ((addr ^ region.base) & keep_mask) == '0;
    shifted   = addr >> (region.sz - 5'd2);
    sub_idx   = shifted[2:0];
    sub_cut   = (region.sz >= 5'(SUB_MIN_N)) && region.sub_off[sub_idx];
    hit       = region.en && in_range && !sub_cut;
  end
endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
  import mpu_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mpu_on,
  input  logic              cfg_we,
  input  logic [IDXW:0]     cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_be,
  output logic              cfg_err,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_priv,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [IDXW-1:0]   rsp_region,
  output logic              rsp_c,
  output logic              rsp_b,
  output logic              rsp_s
);
  mpu_region_t     regions [NREG];
  logic [NREG-1:0] hit_vec;

  mpu_region_regs #(.NREG(NREG)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_be, .cfg_err,
    .regions(regions)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_match
    mpu_region_match u_match (
      .region(regions[i]), .addr(req_addr), .hit(hit_vec[i])
    );
  end

  // Highest-numbered matching region wins
  logic            any_hit;
  logic [IDXW-1:0] win_idx;
  mpu_region_t     win;
  logic            n_hit, n_fault, n_c, n_b, n_s;
  logic [IDXW-1:0] n_region;

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDXW'(i);
      end
    end
    win = regions[win_idx];
    n_hit = 1'b0; n_fault = 1'b0; n_region = '0;
    n_c = 1'b0;   n_b = 1'b0;     n_s = 1'b0;
    if (mpu_on) begin
      if (!any_hit) begin
        n_fault = 1'b1;
      end else begin
        n_hit    = 1'b1;
        n_fault  = perm_denies(win.perm, req_priv, req_write);
        n_region = win_idx;
        n_c = win.c; n_b = win.b; n_s = win.s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_region <= '0;
      rsp_c      <= 1'b0;
      rsp_b      <= 1'b0;
      rsp_s      <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= n_hit;
        rsp_fault  <= n_fault;
        rsp_region <= n_region;
        rsp_c      <= n_c;
        rsp_b      <= n_b;
        rsp_s      <= n_s;
      end
    end
  end

  AST_OFF_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mpu_on) |=> (rsp_valid && !rsp_fault && !rsp_hit)); // R9
  AST_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mpu_on && hit_vec == '0) |=> (rsp_fault && !rsp_hit)); // R4
  AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mpu_on && hit_vec[NREG-1]) |=> (rsp_region == IDXW'(NREG-1))); // R5
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R11
endmodule

// File: tb/sim_mpu_region_check.sv
module sim_mpu_region_check;
  logic clk = 0, rst_n = 0, mpu_on = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0] cfg_be = '0;
  logic cfg_err;
  logic req_valid = 0, req_priv = 0, req_write = 0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_hit, rsp_fault, rsp_c, rsp_b, rsp_s;
  logic [2:0] rsp_region;

  int checks = 0, fails = 0;
  logic [31:0] m_base [8];
  logic [31:0] m_attr [8];

  always #10 clk = ~clk;

  mpu_region_check u0 (.*);

  function automatic logic [31:0] mk(logic en, logic [4:0] n, logic [7:0] so,
                                     logic [1:0] ap, logic c, logic b, logic s);
    return {6'b0, ap, 5'b0, s, b, c, so, 2'b0, n, en};
  endfunction

  function automatic logic [7:0] model(logic [31:0] a, logic priv, logic wr, logic on);
    int sel = -1;
    logic dn;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] size, bal, off;
      int n;
      n    = int'(m_attr[i][5:1]);
      size = 64'd1 << (n + 1);
      bal  = {32'b0, m_base[i]} & ~(size - 1);
      if (m_attr[i][0] && {32'b0, a} >= bal && {32'b0, a} < bal + size) begin
        off = {32'b0, a} - bal;
        if (!(n >= 7 && m_attr[i][8 + int'(off / (size / 8))])) sel = i;
      end
    end
    if (!on) return 8'h00;
    if (sel < 0) return 8'b0100_0000;
    case (m_attr[sel][25:24])
      2'b00: dn = !priv;
      2'b01: dn = 1'b0;
      2'b10: dn = !priv || wr;
      default: dn = wr;
    endcase
    return {1'b1, dn, 3'(sel), m_attr[sel][16], m_attr[sel][17], m_attr[sel][18]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic sel, logic [31:0] d, logic [3:0] be, output logic err);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {3'(idx), sel}; cfg_wdata = d; cfg_be = be;
    if (!sel) begin
      for (int bb = 0; bb < 4; bb++) if (be[bb]) m_base[idx][8*bb +: 8] = d[8*bb +: 8];
    end else if (be == 4'hF) m_attr[idx] = d;
    @(negedge clk);
    cfg_we = 0;
    err = cfg_err;
  endtask

  task automatic setr(int idx, logic [31:0] base, logic [31:0] attr);
    logic e;
    wr(idx, 1'b0, base, 4'hF, e);
    wr(idx, 1'b1, attr, 4'hF, e);
  endtask

  task automatic look(string req, logic [31:0] a, logic priv, logic w);
    logic [7:0] exp;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_priv = priv; req_write = w;
    exp = model(a, priv, w, mpu_on);
    @(negedge clk);
    req_valid = 0;
    chk({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
    chk(req, {24'b0, rsp_hit, rsp_fault, rsp_region, rsp_c, rsp_b, rsp_s}, {24'b0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic e;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_attr[i] = 0; end
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R12 cfg_err", {31'b0, cfg_err}, 0);
    rst_n = 1;
    mpu_on = 1;
    look("R12 R4 empty map faults", 32'h1234_0000, 1, 0);
    @(negedge clk);
    chk("R11 idle after response", {31'b0, rsp_valid}, 0);

    // R3 / R2 / R6: same-base overlap example
    setr(0, 32'h2000_0000, mk(1, 5'd16, 8'h00, 2'b01, 1, 0, 0));
    setr(1, 32'h2000_0000, mk(1, 5'd18, 8'h03, 2'b01, 0, 1, 1));
    look("R3 low subregion falls to 128KB", 32'h2001_0000, 0, 0);
    look("R3 end of 128KB", 32'h2001_FFFF, 0, 1);
    look("R2 subregion 3 of 512KB", 32'h2003_0000, 1, 0);
    look("R6 attributes 011", 32'h2007_FFFC, 1, 1);
    look("R1 just past region", 32'h2008_0000, 1, 0);
    // R8: mask ignored on small region
    setr(2, 32'h3000_0000, mk(1, 5'd6, 8'hFF, 2'b01, 1, 1, 0));
    look("R8 mask ignored N<7", 32'h3000_0010, 0, 0);
    // R2: no fallback -> fault
    setr(3, 32'h4000_0000, mk(1, 5'd7, 8'h01, 2'b01, 0, 0, 1));
    look("R2 masked subregion 0 faults", 32'h4000_0000, 1, 0);
    look("R2 subregion 1 hits", 32'h4000_0020, 1, 0);
    // R5: higher region over the example
    setr(5, 32'h2000_0000, mk(1, 5'd19, 8'h00, 2'b01, 1, 1, 1));
    look("R5 highest wins", 32'h2001_0000, 1, 0);
    // R7: permissions
    setr(6, 32'h5000_0000, mk(1, 5'd11, 8'h00, 2'b11, 1, 0, 1));
    look("R7 write to read-only", 32'h5000_0100, 1, 1);
    look("R7 read of read-only", 32'h5000_0100, 0, 0);
    setr(6, 32'h5000_0000, mk(1, 5'd11, 8'h00, 2'b00, 1, 0, 1));
    look("R7 unprivileged to priv-only", 32'h5000_0100, 0, 0);
    look("R7 privileged write ok", 32'h5000_0100, 1, 1);
    setr(6, 32'h5000_0000, mk(1, 5'd11, 8'h00, 2'b10, 1, 0, 1));
    look("R7 priv write to priv-ro", 32'h5000_0100, 1, 1);
    // R10: partial attribute writes
    wr(6, 1'b1, mk(0, 5'd3, 8'h00, 2'b01, 0, 0, 0), 4'b0111, e);
    chk("R10 err on partial strobe", {31'b0, e}, 1);
    look("R10 attribute unchanged", 32'h5000_0100, 1, 0);
    wr(6, 1'b1, mk(1, 5'd11, 8'h00, 2'b01, 0, 1, 0), 4'hF, e);
    chk("R10 no err on full word", {31'b0, e}, 0);
    wr(6, 1'b0, 32'h0000_00AB, 4'b0001, e);
    chk("R10 base byte write no err", {31'b0, e}, 0);
    look("R10 full write applied", 32'h5000_0100, 0, 1);
    // R9: bypass
    mpu_on = 0;
    look("R9 off no fault", 32'h9999_0000, 0, 1);
    look("R9 off in region", 32'h5000_0100, 0, 1);
    mpu_on = 1;

    // R1 R5 R7 random overlapping regions
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int r = 0; r < 8; r++)
        setr(r, $urandom & 32'h0003_FFFF,
             mk(($urandom % 4) != 0, 5'(4 + $urandom % 14), 8'($urandom),
                2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)));
      for (int k = 0; k < 150; k++) begin
        mpu_on = ($urandom % 10) != 0;
        look("R1 R5 R7 random", $urandom & 32'h0003_FFFF, 1'($urandom), 1'($urandom));
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule